// File: doc/BRIEF.md
# Real-Time Result Burst Serializer

This block sends a fixed burst of four 32-bit result words out on one data pin, with a bit clock beside it, each time the conversion frame enters its settle state. A one-cycle start pulse, taken from the settle-state sync, launches the burst. On that pulse the four words and their four valid flags are captured into shadow storage. The burst then runs from the captured copy, so the producer may rewrite its inputs while the burst is still going out.

Each word goes out as one flag bit followed by 33 bits in total. The flag is the word's captured valid bit. The word's data bits follow, least significant bit first, and the last bit sent is bit 31, the sign. The four words give 132 bit periods. The frame always fills a fixed budget of 140 bit periods, so the last 8 periods are idle. The bit clock runs at half the rate of `clk_2x`, which makes one bit period two `clk_2x` cycles and a whole burst 280 cycles.

Data changes only as the bit clock falls, so it is steady when the receiver samples on the rising edge. A frame-sync marker flags the first bit period. Because the length is fixed, the burst always ends before the next compute pass begins.

Top module: `rt_burst_serializer`

## Requirements
- R1: While reset is asserted, and whenever no burst is running, `busy`, `sclk`, `sdata` and `fsync` are all 0. Reset is asynchronous and active low.
- R2: A start pulse seen at a rising edge while idle begins a burst at once. In the cycle after that edge, `busy` is 1 and `fsync` is 1. `fsync` stays high for exactly the first bit period, which is two cycles, and is 0 for the rest of the burst.
- R3: Every bit period lasts two `clk_2x` cycles. `sclk` is 0 in the first cycle and 1 in the second. `sdata` changes only when a new period begins, which is when `sclk` falls.
- R4: Bit periods 0 to 131 carry the words in the order 0 to 3. Word w fills periods 33*w to 33*w+32. Its first period carries `valid_in[w]`, and the next 32 periods carry `words_in[32*w +: 32]` bit 0 first through bit 31.
- R5: Periods 132 to 139 are idle, with `sdata` 0 while `sclk` keeps toggling. `busy` is high for exactly 280 cycles, which is 140 periods, and then drops.
- R6: The words and flags are captured at the start edge. Changing `words_in` or `valid_in` later does not alter the burst in progress.
- R7: A start pulse during a burst is ignored unless it falls in the burst's final cycle. An ignored pulse does not restart the burst or change its length.
- R8: A start pulse in the final cycle of a burst (period 139, `sclk` high) begins a new burst in the very next cycle with no idle gap. The new burst uses the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_2x | input | 1 | Fast clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Settle-state sync pulse that launches a burst |
| words_in | input | 128 | Four result words, word w in bits 32*w+31 down to 32*w |
| valid_in | input | 4 | Valid flag per word, sent as that word's flag bit |
| sdata | output | 1 | Serial data |
| sclk | output | 1 | Serial bit clock |
| fsync | output | 1 | High during the first bit period of a burst |
| busy | output | 1 | High while a burst occupies its budget |

## Verification
Two events can fall in the same cycle. The first case is the end of one burst and the acceptance of the next. The bench raises `start` so that it is sampled at the edge that closes period 139. It then requires `busy` to stay high, `fsync` to rise at once, and the following burst to carry the newly presented words. The second case is a start pulse arriving mid-burst at the same moment as a rewrite of the inputs. The bench judges it by checking that the data stream still matches the originally captured words and that `busy` still falls after exactly 280 cycles.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  localparam int WORD_W        = 32;
  localparam int N_WORDS       = 4;
  localparam int FRAME_PERIODS = 140;

  // Number of bit periods that carry flag and data bits.
  function automatic int payload_periods(input int n_words, input int word_w);
    return n_words * (word_w + 1);
  endfunction

  // Which word a given bit period belongs to.
  function automatic int slot_word(input int period, input int word_w);
    return period / (word_w + 1);
  endfunction

  // Position inside the word slot: 0 is the flag, 1..word_w are data bits.
  function automatic int slot_pos(input int period, input int word_w);
    return period % (word_w + 1);
  endfunction
endpackage

// File: rtl/rtx_timer.sv
module rtx_timer #(
  parameter int PERIODS = 140
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  output logic                          busy,
  output logic                          phase,
  output logic [$clog2(PERIODS)-1:0]    period,
  output logic                          accept,
  output logic                          last
);
  localparam int PW = $clog2(PERIODS);
  localparam int CW = $clog2(2 * PERIODS + 1);

  assign last   = busy && phase && (period == PW'(PERIODS - 1));
  assign accept = start && (!busy || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      period <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      phase  <= 1'b0;
      period <= '0;
    end else if (last) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      period <= '0;
    end else if (busy) begin
      phase <= !phase;
      if (phase) period <= period + PW'(1);
    end
  end

  // Cycle counter kept only for the length check.
  logic [CW-1:0] busy_cycles;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cycles <= '0;
    else if (accept) busy_cycles <= '0;
    else if (busy)   busy_cycles <= busy_cycles + CW'(1);
  end

  p_budget_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> busy_cycles == CW'(2 * PERIODS - 1));

  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && !(period == '0 && !phase)));

  p_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && start) |=> (busy && period == '0 && !phase));
endmodule

// File: rtl/rtx_shadow.sv
module rtx_shadow #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [N*W-1:0]   words_in,
  input  logic [N-1:0]     valid_in,
  output logic [N*W-1:0]   words_q,
  output logic [N-1:0]     valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      valid_q <= '0;
    end else if (capture) begin
      words_q <= words_in;
      valid_q <= valid_in;
    end
  end

  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(words_q) && $stable(valid_q)));
endmodule

// File: rtl/rtx_bitsel.sv
module rtx_bitsel
  import rtx_pkg::*;
#(
  parameter int N       = 4,
  parameter int W       = 32,
  parameter int PERIODS = 140
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        busy,
  input  logic                        phase,
  input  logic [$clog2(PERIODS)-1:0]  period,
  input  logic [N*W-1:0]              words_q,
  input  logic [N-1:0]                valid_q,
  output logic                        sdata,
  output logic                        sclk,
  output logic                        fsync
);
  localparam int PAYLOAD = payload_periods(N, W);
  localparam int BIW     = $clog2(N * W);
  localparam int NIW     = (N > 1) ? $clog2(N) : 1;

  logic in_payload;
  int   wi;
  int   pos;
  logic [BIW-1:0] bidx;

  always_comb begin
    in_payload = int'(period) < PAYLOAD;
    wi   = slot_word(int'(period), W);
    pos  = slot_pos(int'(period), W);
    bidx = BIW'(wi * W + pos - 1);
    sdata = 1'b0;
    if (busy && in_payload) begin
      if (pos == 0) sdata = valid_q[NIW'(wi)];
      else          sdata = words_q[bidx];
    end
  end

  assign sclk  = busy && phase;
  assign fsync = busy && (period == '0);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sdata && !sclk && !fsync));

  p_edge_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));

  p_tail_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_payload) |-> !sdata);

  p_fsync_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> fsync);
endmodule

// File: rtl/rt_burst_serializer.sv
module rt_burst_serializer
  import rtx_pkg::*;
#(
  parameter int N_W     = N_WORDS,
  parameter int W_W     = WORD_W,
  parameter int PERIODS = FRAME_PERIODS
) (
  input  logic                 clk_2x,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N_W*W_W-1:0]   words_in,
  input  logic [N_W-1:0]       valid_in,
  output logic                 sdata,
  output logic                 sclk,
  output logic                 fsync,
  output logic                 busy
);
  localparam int PW = $clog2(PERIODS);

  logic            phase;
  logic [PW-1:0]   period;
  logic            accept;
  logic            last;
  logic [N_W*W_W-1:0] words_q;
  logic [N_W-1:0]     valid_q;

  rtx_timer #(.PERIODS(PERIODS)) u_timer (
    .clk    (clk_2x),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .phase  (phase),
    .period (period),
    .accept (accept),
    .last   (last)
  );

  rtx_shadow #(.N(N_W), .W(W_W)) u_shadow (
    .clk      (clk_2x),
    .rst_n    (rst_n),
    .capture  (accept),
    .words_in (words_in),
    .valid_in (valid_in),
    .words_q  (words_q),
    .valid_q  (valid_q)
  );

  rtx_bitsel #(.N(N_W), .W(W_W), .PERIODS(PERIODS)) u_bitsel (
    .clk     (clk_2x),
    .rst_n   (rst_n),
    .busy    (busy),
    .phase   (phase),
    .period  (period),
    .words_q (words_q),
    .valid_q (valid_q),
    .sdata   (sdata),
    .sclk    (sclk),
    .fsync   (fsync)
  );

  p_accept_busy_r2: assert property (@(posedge clk_2x) disable iff (!rst_n)
    accept |=> busy);
endmodule

// File: tb/test_rt_burst_serializer.sv
`timescale 1ns/1ps
module test_rt_burst_serializer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [127:0] words_i;
  logic [3:0]   valid_i;
  logic         sdata, sclk, fsync, busy;
  int           checks = 0;
  int           fails  = 0;

  always #10 clk = ~clk;

  rt_burst_serializer i_rt_burst_serializer (
    .clk_2x   (clk),
    .rst_n    (rst_n),
    .start    (start),
    .words_in (words_i),
    .valid_in (valid_i),
    .sdata    (sdata),
    .sclk     (sclk),
    .fsync    (fsync),
    .busy     (busy)
  );

  // {mode[133:132], valid[131:128], words[127:0]}; mode 0 plain,
  // 1 mid-burst start plus input rewrite, 2 start in final cycle.
  localparam logic [133:0] VEC [5] = '{
    {2'd0, 4'b1111, 128'h80000001_7FFFFFFE_DEADBEEF_00000001},
    {2'd0, 4'b0000, 128'hFFFFFFFF_00000000_A5A5A5A5_12345678},
    {2'd1, 4'b1010, 128'h0F0F0F0F_F0F0F0F0_C3C3C3C3_3C3C3C3C},
    {2'd2, 4'b0101, 128'h13579BDF_2468ACE0_FEDCBA98_76543210},
    {2'd0, 4'b1001, 128'h00000000_FFFFFFFF_80000000_00000001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Called at the falling edge just after the accepting rising edge.
  task automatic check_burst(input logic [127:0] w, input logic [3:0] v,
                             input logic [1:0] mode,
                             input logic [127:0] nw, input logic [3:0] nv);
    int   wi  = 0;
    int   pos = 0;
    logic e   = 1'b0;
    for (int k = 0; k < 280; k++) begin
      int    p = k / 2;
      string rq;
      if (k % 2 == 0) begin
        if (p < 132) e = (pos == 0) ? v[wi] : w[wi*32 + pos - 1];
        else         e = 1'b0;
      end
      rq = (p >= 132) ? "R5" : ((mode == 2'd1 && k > 100) ? "R6" : "R4");
      check(rq, sdata, e);
      check("R3", sclk, k % 2);
      check("R2", fsync, (p == 0));
      check((mode == 2'd1) ? "R7" : "R5", busy, 1);
      if (k % 2 == 1 && p < 132) begin
        pos++;
        if (pos == 33) begin pos = 0; wi++; end
      end
      if (mode == 2'd1 && k == 100) begin words_i = ~w; valid_i = ~v; start = 1'b1; end
      if (mode == 2'd1 && k == 102) start = 1'b0;
      if (mode == 2'd2 && k == 279) begin words_i = nw; valid_i = nv; start = 1'b1; end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic armed;
    rst_n = 1'b0; start = 1'b0; words_i = '0; valid_i = '0;
    repeat (3) @(negedge clk);
    check("R1", busy, 0); check("R1", sdata, 0); check("R1", sclk, 0); check("R1", fsync, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", busy, 0); check("R1", sdata, 0);

    armed = 1'b0;
    for (int i = 0; i < 5; i++) begin
      logic [1:0]   md = VEC[i][133:132];
      logic [3:0]   vv = VEC[i][131:128];
      logic [127:0] ww = VEC[i][127:0];
      logic [127:0] nw = (i < 4) ? VEC[i+1][127:0] : '0;
      logic [3:0]   nv = (i < 4) ? VEC[i+1][131:128] : '0;
      if (!armed) begin
        words_i = ww; valid_i = vv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      check_burst(ww, vv, md, nw, nv);
      if (md == 2'd2) begin
        check("R8", busy, 1); check("R8", fsync, 1);
      end else begin
        check("R5", busy, 0); check("R5", sclk, 0); check("R5", sdata, 0);
      end
      armed = (md == 2'd2);
    end

    repeat (5) @(negedge clk);
    check("R1", busy, 0); check("R1", fsync, 0);

    words_i = 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF; valid_i = 4'hF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", busy, 0); check("R1", sdata, 0); check("R1", sclk, 0); check("R1", fsync, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", busy, 0);

    summary();
    $finish;
  end
endmodule